// File: doc/BRIEF.md
# Configurable Serial Shift Engine

This block is a synchronous serial shift unit for SPI-style links. One 16-bit shift register carries data both ways: the outgoing bit leaves at one end while the incoming bit enters at the other end during the same transfer. A down-counting bit counter decides how many bits move. When the counter reaches zero the block raises a completion flag and stops shifting.

Software-side inputs load the parallel data and the bit count. They also choose the bit order (MSB or LSB first), the 8-bit or 16-bit length, the master or slave role and the clock phase. Further inputs enable the serial output and decide whether loading a count clears the completion flag. A software reset input holds the whole block in its reset state.

As a master, the block makes its serial clock from the system clock through a programmable half-period divider, and that clock idles low. As a slave, it takes the serial clock from a pin through a two-flop synchroniser.

Top module: `sershift_engine`

## Requirements
- R1: While `rst_n` is low or `soft_rst` is high at a clock edge, the block returns to its reset state. In that state `data_out`, `count`, `done_flag`, `sclk_out` and `sdo` are all 0, and the state is held until both reset inputs are released.
- R2: With `lsb_first`=0 and `wide16`=0, bits leave from bit 7 downward and enter at bit 0. After 8 bits, `data_out[7:0]` holds the first received bit in bit 7, and `data_out[15:8]` keeps its loaded value.
- R3: With `lsb_first`=1, bits leave from bit 0 upward and enter at bit 7 (8-bit mode) or bit 15 (16-bit mode). After a full-length transfer, received bit i sits in `data_out[i]`.
- R4: With `wide16`=1 and `lsb_first`=0, bits leave from bit 15 downward. After 16 bits, received bit i sits in `data_out[15-i]`.
- R5: `count` drops by exactly one per capture edge and never changes otherwise, except through `load_cnt`. Once it is zero, shifting stops and a master makes no further rising SCLK edge.
- R6: `done_flag` becomes 1 when `count` reaches zero by decrementing, or when `load_cnt` loads a zero.
- R7: Loading a nonzero count clears `done_flag` if `flag_hold`=0 and leaves it set if `flag_hold`=1. `flag_clr` clears it.
- R8: With `cpha`=0, data is captured on falling SCLK edges and changed on rising ones. With `cpha`=1, data is captured on rising edges and changed on falling ones. `data_out` never changes on a change edge.
- R9: In master mode, `sclk_out` idles low and each high or low phase lasts `half_div` system clocks. A `half_div` of 0 acts as 1, so the clock period is at least 2 system clocks.
- R10: In slave mode, `sclk_out` stays 0 and the block shifts on the edges of `sclk_in`, which pass through a two-flop synchroniser.
- R11: While `out_en`=0, `sdo` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| soft_rst | input | 1 | Software reset, active high, holds the block reset |
| master | input | 1 | 1 = generate SCLK, 0 = take SCLK from `sclk_in` |
| lsb_first | input | 1 | 1 = LSB first, 0 = MSB first |
| wide16 | input | 1 | 1 = 16-bit shift, 0 = 8-bit shift |
| cpha | input | 1 | Clock phase select |
| out_en | input | 1 | Serial output enable |
| flag_hold | input | 1 | 1 = loading a count does not clear `done_flag` |
| half_div | input | DIV_W | Master SCLK half period in system clocks |
| load_data | input | 1 | Load `load_val` into the shift register |
| load_val | input | 16 | Parallel data to load |
| load_cnt | input | 1 | Load `cnt_val` into the bit counter |
| cnt_val | input | CNT_W | Bit count to load |
| flag_clr | input | 1 | Clear `done_flag` |
| sclk_in | input | 1 | Serial clock from the pin (slave) |
| sdi | input | 1 | Serial data in |
| sclk_out | output | 1 | Generated serial clock (master) |
| sdo | output | 1 | Serial data out |
| data_out | output | 16 | Shift register contents |
| count | output | CNT_W | Bits remaining |
| done_flag | output | 1 | Transfer complete flag |

## Verification
A wrong bit order or a wrong insertion end shows up in the `sdo` sequence at the first capture edge. It shows up in `data_out` at the end of the transfer. A phase error is visible one cycle after the wrong edge, because `data_out` then moves on a change edge. A counter that is off by one gives an extra or missing SCLK pulse and a flag raised too early or too late, and the bench counts the pulses directly. A divider fault changes the measured high-phase length on the first pulse.

// File: rtl/sershift_pkg.sv
// Package: shared types and helpers for the serial shift engine.
// Assumes a 16-bit physical shift register with an 8-bit sub-mode in the low byte.
package sershift_pkg;

    localparam int unsigned SR_W = 16;
    localparam int unsigned SR_HALF = SR_W / 2;

    typedef enum logic {
        PH_CHANGE_FIRST  = 1'b0,
        PH_CAPTURE_FIRST = 1'b1
    } phase_e;

    // Bit currently at the outgoing end of the register.
    function automatic logic exit_bit(input logic [SR_W-1:0] d,
                                      input logic lsb, input logic wide);
        if (lsb)
            return d[0];
        else if (wide)
            return d[SR_W-1];
        else
            return d[SR_HALF-1];
    endfunction

    // Register after one shift, with the new bit entering opposite the exit end.
    function automatic logic [SR_W-1:0] push_bit(input logic [SR_W-1:0] d,
                                                 input logic b,
                                                 input logic lsb, input logic wide);
        logic [SR_W-1:0] r;
        if (!lsb) begin
            if (wide) r = {d[SR_W-2:0], b};
            else      r = {d[SR_W-1:SR_HALF], d[SR_HALF-2:0], b};
        end else begin
            if (wide) r = {b, d[SR_W-1:1]};
            else      r = {d[SR_W-1:SR_HALF], b, d[SR_HALF-1:1]};
        end
        return r;
    endfunction

endpackage

// File: rtl/sershift_clkgen.sv
// Master SCLK generator: divides the system clock by 2*half_div (half_div 0 acts as 1).
// Assumes the bit counter is fed back through cnt_busy; issues single-cycle edge strobes
// that coincide with the register update of sclk, so the counter is current before the
// next edge is decided.
module sershift_clkgen #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_ok,
    input  logic             enable,
    input  logic             cnt_busy,
    input  logic [DIV_W-1:0] half_div,
    output logic             sclk,
    output logic             rise_now,
    output logic             fall_now
);
    logic [DIV_W-1:0] div_cnt;
    logic [DIV_W-1:0] half_eff;
    logic             running;
    logic             tick;

    // Effective half period, never below one cycle.
    always_comb half_eff = (half_div == '0) ? {{(DIV_W-1){1'b0}}, 1'b1} : half_div;

    // Keep running while bits remain or to return a high clock to idle.
    always_comb running = enable & (cnt_busy | sclk);

    always_comb tick = (div_cnt >= half_eff - 1'b1);

    always_comb begin
        rise_now = running & tick & ~sclk;
        fall_now = running & tick & sclk;
    end

    // Divider counter and clock toggle.
    always_ff @(posedge clk) begin
        if (!rst_ok || !enable) begin
            div_cnt <= '0;
            sclk    <= 1'b0;
        end else if (running) begin
            if (tick) begin
                div_cnt <= '0;
                sclk    <= ~sclk;
            end else begin
                div_cnt <= div_cnt + 1'b1;
            end
        end else begin
            div_cnt <= '0;
        end
    end

endmodule

// File: rtl/sershift_sync.sv
// Slave SCLK synchroniser: two-flop synchroniser plus one history flop for edge detection.
// Assumes the external clock half period spans several system clocks.
module sershift_sync (
    input  logic clk,
    input  logic rst_ok,
    input  logic pin,
    output logic rise_ev,
    output logic fall_ev
);
    logic s1, s2, s3;

    // Synchronise the pin and keep one cycle of history.
    always_ff @(posedge clk) begin
        if (!rst_ok) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
            s3 <= 1'b0;
        end else begin
            s1 <= pin;
            s2 <= s1;
            s3 <= s2;
        end
    end

    // Edge strobes from the synchronised level.
    always_comb begin
        rise_ev = s2 & ~s3;
        fall_ev = ~s2 & s3;
    end

endmodule

// File: rtl/sershift_counter.sv
// Bit counter and completion flag: counts capture edges down to zero.
// Assumes cap_ev is already gated to nonzero counts; load has priority over counting.
module sershift_counter #(
    parameter int unsigned CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_ok,
    input  logic             load_cnt,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             cap_ev,
    input  logic             flag_hold,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] count,
    output logic             done_flag,
    output logic             busy
);
    always_comb busy = (count != '0);

    // Counter: load or decrement per captured bit.
    always_ff @(posedge clk) begin
        if (!rst_ok)
            count <= '0;
        else if (load_cnt)
            count <= cnt_val;
        else if (cap_ev)
            count <= count - 1'b1;
    end

    // Completion flag: set on reaching zero, auto-cleared on nonzero load unless held.
    always_ff @(posedge clk) begin
        if (!rst_ok)
            done_flag <= 1'b0;
        else if (load_cnt) begin
            if (cnt_val == '0)
                done_flag <= 1'b1;
            else if (!flag_hold)
                done_flag <= 1'b0;
        end else if (cap_ev && count == {{(CNT_W-1){1'b0}}, 1'b1})
            done_flag <= 1'b1;
        else if (flag_clr)
            done_flag <= 1'b0;
    end

endmodule

// File: rtl/sershift_core.sv
// Shift register core: shifts in on capture edges, updates the output bit on change edges.
// Assumes edge strobes are single-cycle and mutually exclusive.
module sershift_core
    import sershift_pkg::*;
(
    input  logic            clk,
    input  logic            rst_ok,
    input  logic            load_data,
    input  logic [SR_W-1:0] load_val,
    input  logic            cap_ev,
    input  logic            chg_ev,
    input  logic            sdi,
    input  logic            lsb,
    input  logic            wide,
    output logic [SR_W-1:0] data,
    output logic            out_bit
);
    // Shift register: parallel load or one shift per captured bit.
    always_ff @(posedge clk) begin
        if (!rst_ok)
            data <= '0;
        else if (load_data)
            data <= load_val;
        else if (cap_ev)
            data <= push_bit(data, sdi, lsb, wide);
    end

    // Output bit: presents the exit bit after load and on each change edge.
    always_ff @(posedge clk) begin
        if (!rst_ok)
            out_bit <= 1'b0;
        else if (load_data)
            out_bit <= exit_bit(load_val, lsb, wide);
        else if (chg_ev)
            out_bit <= exit_bit(data, lsb, wide);
    end

endmodule

// File: rtl/sershift_engine.sv
// Top: serial shift engine usable as SPI master or slave.
// Assumes software-side controls are synchronous to clk and stable during a transfer.
module sershift_engine
    import sershift_pkg::*;
#(
    parameter int unsigned CNT_W = 5,
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             master,
    input  logic             lsb_first,
    input  logic             wide16,
    input  logic             cpha,
    input  logic             out_en,
    input  logic             flag_hold,
    input  logic [DIV_W-1:0] half_div,
    input  logic             load_data,
    input  logic [SR_W-1:0]  load_val,
    input  logic             load_cnt,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             flag_clr,
    input  logic             sclk_in,
    input  logic             sdi,
    output logic             sclk_out,
    output logic             sdo,
    output logic [SR_W-1:0]  data_out,
    output logic [CNT_W-1:0] count,
    output logic             done_flag
);
    logic   rst_ok;
    logic   busy;
    logic   m_rise, m_fall, s_rise, s_fall;
    logic   rise_ev, fall_ev, cap_ev, chg_ev;
    logic   out_bit;
    phase_e phase;

    // Combined synchronous reset: hardware reset or software reset.
    always_comb rst_ok = rst_n & ~soft_rst;

    always_comb phase = phase_e'(cpha);

    sershift_clkgen #(.DIV_W(DIV_W)) u_gen (
        .clk      (clk),
        .rst_ok   (rst_ok),
        .enable   (master),
        .cnt_busy (busy),
        .half_div (half_div),
        .sclk     (sclk_out),
        .rise_now (m_rise),
        .fall_now (m_fall)
    );

    sershift_sync u_sync (
        .clk     (clk),
        .rst_ok  (rst_ok),
        .pin     (sclk_in),
        .rise_ev (s_rise),
        .fall_ev (s_fall)
    );

    // Edge source selection and capture/change mapping by phase.
    always_comb begin
        rise_ev = master ? m_rise : s_rise;
        fall_ev = master ? m_fall : s_fall;
        if (phase == PH_CAPTURE_FIRST) begin
            cap_ev = rise_ev & busy;
            chg_ev = fall_ev;
        end else begin
            cap_ev = fall_ev & busy;
            chg_ev = rise_ev;
        end
    end

    sershift_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_ok    (rst_ok),
        .load_cnt  (load_cnt),
        .cnt_val   (cnt_val),
        .cap_ev    (cap_ev),
        .flag_hold (flag_hold),
        .flag_clr  (flag_clr),
        .count     (count),
        .done_flag (done_flag),
        .busy      (busy)
    );

    sershift_core u_core (
        .clk       (clk),
        .rst_ok    (rst_ok),
        .load_data (load_data),
        .load_val  (load_val),
        .cap_ev    (cap_ev),
        .chg_ev    (chg_ev),
        .sdi       (sdi),
        .lsb       (lsb_first),
        .wide      (wide16),
        .data      (data_out),
        .out_bit   (out_bit)
    );

    // Output gating by enable.
    always_comb sdo = out_en & out_bit;

endmodule

// File: rtl/sershift_chk.sv
// Checker: temporal properties of the serial shift engine, bound to the top.
module sershift_chk #(
    parameter int unsigned CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             soft_rst,
    input logic             master,
    input logic             out_en,
    input logic             load_cnt,
    input logic             flag_hold,
    input logic             flag_clr,
    input logic [CNT_W-1:0] count,
    input logic             done_flag,
    input logic             sclk_out,
    input logic             sdo
);
    // R11
    sdo_gate_chk: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
        !out_en |-> !sdo);

    // R10
    slave_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
        !master |=> !sclk_out);

    // R5
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
        !load_cnt |=> (count == $past(count) || count == $past(count) - 1'b1));

    // R5
    no_extra_edge_chk: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
        $rose(sclk_out) |-> ($past(count) != '0));

    // R6
    flag_on_zero_chk: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
        ($past(rst_n) && !$past(soft_rst) && !$past(load_cnt) &&
         $past(count) != '0 && count == '0) |-> done_flag);

    // R7
    flag_kept_chk: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
        (done_flag && flag_hold && load_cnt && !flag_clr) |=> done_flag);

    // R9
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
        (count == '0 && !sclk_out) |=> !sclk_out);

endmodule

bind sershift_engine sershift_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/sershift_engine_test.sv
// Directed bench for the serial shift engine; one task per scenario.
module sershift_engine_test;

    localparam int unsigned CNT_W = 5;
    localparam int unsigned DIV_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             soft_rst = 1'b0;
    logic             master = 1'b0;
    logic             lsb_first = 1'b0;
    logic             wide16 = 1'b0;
    logic             cpha = 1'b0;
    logic             out_en = 1'b1;
    logic             flag_hold = 1'b0;
    logic [DIV_W-1:0] half_div = 8'd1;
    logic             load_data = 1'b0;
    logic [15:0]      load_val = '0;
    logic             load_cnt = 1'b0;
    logic [CNT_W-1:0] cnt_val = '0;
    logic             flag_clr = 1'b0;
    logic             sclk_in = 1'b0;
    logic             sdi = 1'b0;
    logic             sclk_out;
    logic             sdo;
    logic [15:0]      data_out;
    logic [CNT_W-1:0] count;
    logic             done_flag;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    always #10 clk = ~clk;

    sershift_engine #(.CNT_W(CNT_W), .DIV_W(DIV_W)) uut (.*);

    // Watchdog.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d cycles, expected fewer", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(data_out == 16'h0, "R1", "data after reset", data_out, 0);
        chk(count == '0, "R1", "count after reset", count, 0);
        chk({done_flag, sclk_out, sdo} == 3'b0, "R1", "flag/sclk/sdo after reset",
            {done_flag, sclk_out, sdo}, 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_master(input logic [15:0] tx, input logic [15:0] rx,
                            input bit lsb, input bit wide, input bit ph,
                            input logic [7:0] half, input bit oe, input string req);
        int n = wide ? 16 : 8;
        int bitidx = 0;
        int rises = 0;
        int hi_len = 0;
        int guard = 0;
        bit first_pulse = 1'b1;
        bit bad_phase = 1'b0;
        logic [15:0] got = '0;
        logic [15:0] exp_tx = '0;
        logic [15:0] exp_data;
        logic prev_sclk, prev_sdo;
        logic [15:0] prev_data;
        int exp_half = (half == 0) ? 1 : int'(half);

        master = 1'b1; lsb_first = lsb; wide16 = wide; cpha = ph; out_en = oe;
        flag_hold = 1'b0; half_div = half;
        @(negedge clk);
        load_data = 1'b1; load_val = tx;
        @(negedge clk);
        load_data = 1'b0; load_cnt = 1'b1; cnt_val = CNT_W'(n);
        sdi = rx[0];
        @(negedge clk);
        load_cnt = 1'b0;
        prev_sclk = sclk_out; prev_sdo = sdo; prev_data = data_out;
        while (!(bitidx == n && sclk_out == 1'b0) && guard < 5000) begin
            @(negedge clk);
            guard++;
            if (sclk_out != prev_sclk) begin
                if ((sclk_out == 1'b1) == ph) begin
                    got[bitidx] = prev_sdo;
                    bitidx++;
                    sdi = (bitidx < n) ? rx[bitidx] : 1'b0;
                end else if (data_out != prev_data) begin
                    bad_phase = 1'b1;
                end
                if (sclk_out) rises++;
                if (!sclk_out) first_pulse = 1'b0;
            end else if (data_out != prev_data) begin
                bad_phase = 1'b1;
            end
            if (sclk_out && first_pulse) hi_len++;
            prev_sclk = sclk_out; prev_sdo = sdo; prev_data = data_out;
        end
        // Watch for stray clock pulses after completion.
        repeat (12) begin
            @(negedge clk);
            if (sclk_out) rises++;
        end
        for (int i = 0; i < n; i++)
            exp_tx[i] = oe ? (lsb ? tx[i] : tx[n-1-i]) : 1'b0;
        exp_data = wide ? 16'h0 : {tx[15:8], 8'h00};
        for (int i = 0; i < n; i++) begin
            if (lsb) exp_data[i] = rx[i];
            else     exp_data[n-1-i] = rx[i];
        end
        chk(got == exp_tx, oe ? req : "R11", "serial out sequence", got, exp_tx);
        chk(data_out == exp_data, req, "received data", data_out, exp_data);
        chk(rises == n, "R5", "SCLK rising edges", rises, n);
        chk(count == '0, "R5", "count at end", count, 0);
        chk(done_flag == 1'b1, "R6", "flag after transfer", done_flag, 1);
        chk(!bad_phase, "R8", "data moved only on capture edges", bad_phase, 0);
        chk(hi_len == exp_half, "R9", "SCLK high phase length", hi_len, exp_half);
    endtask

    task automatic t_slave(input logic [15:0] tx, input logic [15:0] rx,
                           input bit lsb, input bit wide, input bit ph, input string req);
        int n = wide ? 16 : 8;
        bit clk_seen = 1'b0;
        logic [15:0] got = '0;
        logic [15:0] exp_tx = '0;
        logic [15:0] exp_data;

        master = 1'b0; lsb_first = lsb; wide16 = wide; cpha = ph; out_en = 1'b1;
        flag_hold = 1'b0; sclk_in = 1'b0;
        @(negedge clk);
        load_data = 1'b1; load_val = tx;
        @(negedge clk);
        load_data = 1'b0; load_cnt = 1'b1; cnt_val = CNT_W'(n);
        @(negedge clk);
        load_cnt = 1'b0;
        for (int i = 0; i < n; i++) begin
            sdi = rx[i];
            if (ph) got[i] = sdo;
            sclk_in = 1'b1;
            repeat (8) begin @(negedge clk); if (sclk_out) clk_seen = 1'b1; end
            if (!ph) got[i] = sdo;
            sclk_in = 1'b0;
            repeat (8) begin @(negedge clk); if (sclk_out) clk_seen = 1'b1; end
        end
        for (int i = 0; i < n; i++)
            exp_tx[i] = lsb ? tx[i] : tx[n-1-i];
        exp_data = wide ? 16'h0 : {tx[15:8], 8'h00};
        for (int i = 0; i < n; i++) begin
            if (lsb) exp_data[i] = rx[i];
            else     exp_data[n-1-i] = rx[i];
        end
        chk(got == exp_tx, "R10", {"slave serial out ", req}, got, exp_tx);
        chk(data_out == exp_data, "R10", {"slave received data ", req}, data_out, exp_data);
        chk(!clk_seen, "R10", "sclk_out quiet in slave mode", clk_seen, 0);
        chk(done_flag && count == '0, "R6", "slave completion", {done_flag, count}, {1'b1, 5'd0});
    endtask

    task automatic t_flag();
        master = 1'b0; flag_hold = 1'b0;
        @(negedge clk);
        load_cnt = 1'b1; cnt_val = 5'd5;
        @(negedge clk);
        load_cnt = 1'b0;
        chk(!done_flag && count == 5'd5, "R7", "nonzero load clears flag", {done_flag, count}, {1'b0, 5'd5});
        load_cnt = 1'b1; cnt_val = 5'd0;
        @(negedge clk);
        load_cnt = 1'b0;
        chk(done_flag == 1'b1, "R6", "zero load sets flag", done_flag, 1);
        flag_hold = 1'b1; load_cnt = 1'b1; cnt_val = 5'd3;
        @(negedge clk);
        load_cnt = 1'b0;
        chk(done_flag == 1'b1 && count == 5'd3, "R7", "held flag survives load", {done_flag, count}, {1'b1, 5'd3});
        repeat (4) @(negedge clk);
        chk(count == 5'd3, "R5", "count static without edges", count, 3);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        chk(done_flag == 1'b0, "R7", "explicit clear", done_flag, 0);
        flag_hold = 1'b0; load_cnt = 1'b1; cnt_val = 5'd0;
        @(negedge clk);
        load_cnt = 1'b0;
    endtask

    task automatic t_soft_reset();
        master = 1'b1; lsb_first = 1'b0; wide16 = 1'b1; cpha = 1'b0; out_en = 1'b1;
        half_div = 8'd4;
        @(negedge clk);
        load_data = 1'b1; load_val = 16'hFFFF;
        @(negedge clk);
        load_data = 1'b0; load_cnt = 1'b1; cnt_val = 5'd16;
        @(negedge clk);
        load_cnt = 1'b0;
        repeat (20) @(negedge clk);
        soft_rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(count == '0 && data_out == 16'h0, "R1", "soft reset clears state",
            {count, data_out}, 0);
        chk({done_flag, sclk_out, sdo} == 3'b0, "R1", "soft reset clears outputs",
            {done_flag, sclk_out, sdo}, 0);
        load_cnt = 1'b1; cnt_val = 5'd4;
        @(negedge clk);
        load_cnt = 1'b0;
        chk(count == '0, "R1", "held in soft reset", count, 0);
        soft_rst = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        t_reset();
        t_master(16'h00A5, 16'h003C, 1'b0, 1'b0, 1'b0, 8'd1, 1'b1, "R2");
        t_master(16'h7E96, 16'h0051, 1'b1, 1'b0, 1'b1, 8'd3, 1'b1, "R3");
        t_master(16'hC3A1, 16'h5AF0, 1'b0, 1'b1, 1'b1, 8'd2, 1'b1, "R4");
        t_master(16'h1234, 16'h8421, 1'b1, 1'b1, 1'b0, 8'd0, 1'b1, "R3");
        t_master(16'h00FF, 16'h00A9, 1'b0, 1'b0, 1'b1, 8'd1, 1'b0, "R2");
        t_flag();
        t_slave(16'h0069, 16'h00C5, 1'b0, 1'b0, 1'b0, "R2");
        t_slave(16'hB00D, 16'h36E1, 1'b1, 1'b1, 1'b1, "R3");
        t_soft_reset();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule